// File: doc/BRIEF.md
# Byte FIFO Data Engine for a Card Host Controller

This block carries the data phase of a card transfer between a register-mapped host port and a byte-wide card port. Data read from the card goes into a 32-byte circular receive queue. Data written by the host goes into a 32-byte circular transmit window, which sits in one half of a 64-byte buffer. A partial-buffer flush drops the queued transmit bytes and moves the window to the other half.

A command sequencer loads a transfer by pulsing a start input with a direction. The engine copies the product of the block-length and block-count registers into a byte counter. It then moves one byte per cycle over valid/ready byte streams until the counter reaches zero. It raises a receive request for every byte queued and keeps a transmit request up while a write transfer still needs bytes. At the end it reports data done, and also programming done when the transfer was a write.

A host access covers 1 to 4 bytes. The first byte in queue order sits in the most significant lane of the access. A card that holds its handshake low stalls the engine and no byte is lost.

Top module: `card_data_engine`

## Requirements
- R1: In a read transfer, `card_rx_ready` is high only while the transfer is active, bytes remain and the receive queue holds fewer than 32 bytes. Queued bytes come out in arrival order, including across pointer wrap. `card_rx_ready` is never high in a write transfer.
- R2: In a write transfer, `card_tx_valid` is high only while the transfer is active, bytes remain and the transmit queue is not empty. Bytes leave in the order they were accepted, and each handshake lowers the remaining count by one.
- R3: `rx_req` rises in the cycle after each byte enters the receive queue. A host read of the receive port (address 3) clears it, unless a byte enters in the same cycle.
- R4: While a write transfer is active, `tx_req` is re-evaluated at start, on every host transmit-port write (address 4), on every flush and on every byte sent. After each evaluation it equals "bytes still remain". A transmit-port write outside an active write transfer clears it.
- R5: One cycle after the remaining count of an active transfer is zero, `busy` falls and `data_done` rises. `prog_done` rises together with it only for a write transfer. `xfer_start` clears both flags. A zero-length transfer completes at once.
- R6: `host_size` holds the access length N minus 1. A receive-port read pops min(N, queued) bytes. The k-th popped byte (k = 0 first) appears in bits [8(N-k)-1 : 8(N-k)-8]. Lanes with no byte, and bits above 8N, read as zero.
- R7: A transmit-port write of N bytes takes the k-th byte from bits [8(N-k)-1 : 8(N-k)-8]. Bytes are accepted only while the transmit queue holds fewer than 32. Any excess bytes are discarded.
- R8: A write to address 5 with bit 0 set empties the transmit queue and moves the window to the other buffer half. Bytes written afterwards are the next to be sent. A write to address 5 with bit 0 clear has no effect.
- R9: Address 0 holds the block length (low 12 bits kept) and address 1 holds the block count (low 16 bits kept). Address 2 reads back the block count and ignores writes. `xfer_start` loads length times count as the byte count.
- R10: `xfer_stop` ends an active transfer without setting `data_done` or `prog_done`. `card_rx_ready` and `card_tx_valid` stay low after it.
- R11: While `card_tx_valid` is high and `card_tx_ready` is low, `card_tx_valid` stays high and `card_tx_data` stays stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_addr | input | 3 | Register index |
| host_size | input | 2 | Access length in bytes minus one |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, registered, valid the cycle after `host_re` |
| xfer_start | input | 1 | Load byte count and start a transfer |
| xfer_write | input | 1 | Direction for `xfer_start`: 1 = write to card |
| xfer_stop | input | 1 | Abort the active transfer |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from card |
| card_rx_ready | output | 1 | Engine takes the offered byte |
| card_tx_valid | output | 1 | Engine offers a byte to the card |
| card_tx_data | output | 8 | Byte to card |
| card_tx_ready | input | 1 | Card takes the offered byte |
| busy | output | 1 | Transfer active |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |
| data_done | output | 1 | Transfer finished |
| prog_done | output | 1 | Write transfer finished |

## Verification
The hardest states to reach are the two queue limits while bytes are still outstanding. One is a receive queue held full with the card still offering data. The other is a transmit queue that refuses the tail of a host word. The bench programs transfers longer than 32 bytes. It either lets the card fill the receive queue while the host stays idle, or keeps the card from taking bytes while the host writes more than 32 bytes. It then drains in steps and checks byte order across pointer wrap. A window flip is set up by queueing bytes that the card cannot take yet, and card stalls come from a sink whose ready pattern toggles every two cycles.

// File: rtl/cde_pkg.sv
package cde_pkg;
  localparam logic [2:0] ADDR_BLK_LEN  = 3'd0;
  localparam logic [2:0] ADDR_BLK_CNT  = 3'd1;
  localparam logic [2:0] ADDR_BLK_LEFT = 3'd2;
  localparam logic [2:0] ADDR_RX_PORT  = 3'd3;
  localparam logic [2:0] ADDR_TX_PORT  = 3'd4;
  localparam logic [2:0] ADDR_FLUSH    = 3'd5;
endpackage

// File: rtl/cde_byte_store.sv
// Byte array with several write lanes and several combinational read lanes.
module cde_byte_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned NWR   = 4,
  parameter int unsigned NRD   = 4,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic [NWR-1:0]           wr_en,
  input  logic [NWR-1:0][AW-1:0]   wr_addr,
  input  logic [NWR-1:0][7:0]      wr_data,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][7:0]      rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(NWR); i++) begin
      if (wr_en[i]) mem[wr_addr[i]] <= wr_data[i];
    end
  end

  for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
    assign rd_data[g] = mem[rd_addr[g]];
  end
endmodule

// File: rtl/cde_xfer_ctrl.sv
// Remaining-byte counter, transfer state, completion flags and transmit request.
module cde_xfer_ctrl #(
  parameter int unsigned CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wr,
  input  logic [CNT_W-1:0] start_len,
  input  logic             stop,
  input  logic             byte_done,
  input  logic             tx_eval,
  output logic             busy,
  output logic             wr_mode,
  output logic [CNT_W-1:0] remaining,
  output logic             data_done,
  output logic             prog_done,
  output logic             tx_req
);
  logic [CNT_W-1:0] rem_after;
  assign rem_after = remaining - CNT_W'(byte_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      wr_mode   <= 1'b0;
      remaining <= '0;
      data_done <= 1'b0;
      prog_done <= 1'b0;
      tx_req    <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      wr_mode   <= start_wr;
      remaining <= start_len;
      data_done <= 1'b0;
      prog_done <= 1'b0;
      tx_req    <= start_wr && (start_len != '0);
    end else if (stop) begin
      busy <= 1'b0;
    end else begin
      if (busy && byte_done) remaining <= rem_after;
      if (busy && remaining == '0) begin
        busy      <= 1'b0;
        data_done <= 1'b1;
        prog_done <= wr_mode;
      end
      if (busy && wr_mode) begin
        if (tx_eval || byte_done) tx_req <= (rem_after != '0);
      end else if (tx_eval) begin
        tx_req <= 1'b0;
      end
    end
  end

  // R5: a zero count in an active transfer completes it on the next edge
  p_done_r5: assert property (@(posedge clk) disable iff (rst)
    busy && remaining == '0 && !start && !stop |=> data_done && !busy);
  // R5: programming done only accompanies a finished write
  p_prog_only_write_r5: assert property (@(posedge clk) disable iff (rst)
    prog_done |-> wr_mode && data_done);
  // R4: the transmit request belongs to write transfers
  p_txreq_write_r4: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> wr_mode);
  // R2: no byte is moved once the count is exhausted
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> busy && remaining != '0);
endmodule

// File: rtl/card_data_engine.sv
module card_data_engine
  import cde_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned LEN_W      = 12,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned LANES      = 4,
  localparam int unsigned DATA_W    = 8 * LANES,
  localparam int unsigned SZ_W      = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [2:0]        host_addr,
  input  logic [SZ_W-1:0]   host_size,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              xfer_start,
  input  logic              xfer_write,
  input  logic              xfer_stop,
  input  logic              card_rx_valid,
  input  logic [7:0]        card_rx_data,
  output logic              card_rx_ready,
  output logic              card_tx_valid,
  output logic [7:0]        card_tx_data,
  input  logic              card_tx_ready,
  output logic              busy,
  output logic              rx_req,
  output logic              tx_req,
  output logic              data_done,
  output logic              prog_done
);
  localparam int unsigned PTR_W  = $clog2(FIFO_DEPTH);
  localparam int unsigned LVL_W  = PTR_W + 1;
  localparam int unsigned TX_AW  = PTR_W + 1;
  localparam int unsigned REM_W  = LEN_W + CNT_W;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic [LEN_W-1:0] blk_len_q;
  logic [CNT_W-1:0] blk_cnt_q;
  logic [LVL_W-1:0] rx_level_q, tx_level_q;
  logic [PTR_W-1:0] rx_rd_q, tx_rd_q;
  logic             tx_half_q;
  logic [REM_W-1:0] remaining;
  logic             wr_mode;

  // host decode
  logic host_rx_rd, host_tx_wr, host_flush;
  logic [LVL_W-1:0] acc_n, n_pop, n_acc, tx_room;
  assign host_rx_rd = host_re && (host_addr == ADDR_RX_PORT);
  assign host_tx_wr = host_we && (host_addr == ADDR_TX_PORT);
  assign host_flush = host_we && (host_addr == ADDR_FLUSH) && host_wdata[0];
  assign acc_n      = LVL_W'(host_size) + LVL_W'(1);
  assign tx_room    = FULL_LVL - tx_level_q;
  assign n_pop = host_rx_rd ? ((acc_n < rx_level_q) ? acc_n : rx_level_q) : '0;
  assign n_acc = host_tx_wr ? ((acc_n < tx_room) ? acc_n : tx_room) : '0;

  // card handshakes
  logic rx_push, tx_drain, gate;
  assign gate          = busy && (remaining != '0) && !xfer_start && !xfer_stop;
  assign card_rx_ready = gate && !wr_mode && (rx_level_q < FULL_LVL);
  assign card_tx_valid = gate && wr_mode && (tx_level_q != '0);
  assign rx_push       = card_rx_ready && card_rx_valid;
  assign tx_drain      = card_tx_valid && card_tx_ready;

  // receive storage
  logic [0:0]                 rx_we;
  logic [0:0][PTR_W-1:0]      rx_wa;
  logic [0:0][7:0]            rx_wd;
  logic [LANES-1:0][PTR_W-1:0] rx_ra;
  logic [LANES-1:0][7:0]       rx_bytes;
  assign rx_we[0] = rx_push;
  assign rx_wa[0] = rx_rd_q + rx_level_q[PTR_W-1:0];
  assign rx_wd[0] = card_rx_data;
  for (genvar g = 0; g < int'(LANES); g++) begin : g_rx_ra
    assign rx_ra[g] = rx_rd_q + PTR_W'(g);
  end

  cde_byte_store #(.DEPTH(FIFO_DEPTH), .NWR(1), .NRD(LANES)) rx_store_i (
    .clk(clk), .wr_en(rx_we), .wr_addr(rx_wa), .wr_data(rx_wd),
    .rd_addr(rx_ra), .rd_data(rx_bytes));

  // transmit storage: two windows, the half bit selects the active one
  logic [LANES-1:0]            tx_we;
  logic [LANES-1:0][TX_AW-1:0] tx_wa;
  logic [LANES-1:0][7:0]       tx_wd;
  logic [0:0][TX_AW-1:0]       tx_ra;
  logic [0:0][7:0]             tx_rd;

  always_comb begin
    for (int k = 0; k < int'(LANES); k++) begin
      tx_we[k] = (LVL_W'(k) < n_acc);
      tx_wa[k] = {tx_half_q, PTR_W'(tx_rd_q + tx_level_q[PTR_W-1:0] + PTR_W'(k))};
      tx_wd[k] = '0;
      if (LVL_W'(k) < acc_n) tx_wd[k] = host_wdata[(int'(acc_n) - 1 - k) * 8 +: 8];
    end
  end
  assign tx_ra[0]     = {tx_half_q, tx_rd_q};
  assign card_tx_data = tx_rd[0];

  cde_byte_store #(.DEPTH(2 * FIFO_DEPTH), .NWR(LANES), .NRD(1)) tx_store_i (
    .clk(clk), .wr_en(tx_we), .wr_addr(tx_wa), .wr_data(tx_wd),
    .rd_addr(tx_ra), .rd_data(tx_rd));

  // receive word packing: first popped byte in the top lane of the access
  logic [DATA_W-1:0] rx_word;
  always_comb begin
    rx_word = '0;
    for (int k = 0; k < int'(LANES); k++) begin
      if (LVL_W'(k) < n_pop) rx_word[(int'(acc_n) - 1 - k) * 8 +: 8] = rx_bytes[k];
    end
  end

  // queue pointers and levels
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_level_q <= '0;
      rx_rd_q    <= '0;
      tx_level_q <= '0;
      tx_rd_q    <= '0;
      tx_half_q  <= 1'b0;
    end else if (xfer_start) begin
      rx_level_q <= '0;
      tx_level_q <= '0;
    end else begin
      rx_level_q <= rx_level_q + LVL_W'(rx_push) - n_pop;
      rx_rd_q    <= rx_rd_q + n_pop[PTR_W-1:0];
      tx_rd_q    <= tx_rd_q + PTR_W'(tx_drain);
      if (host_flush) begin
        tx_level_q <= '0;
        tx_half_q  <= ~tx_half_q;
      end else begin
        tx_level_q <= tx_level_q + n_acc - LVL_W'(tx_drain);
      end
    end
  end

  // receive request
  always_ff @(posedge clk) begin
    if (rst)             rx_req <= 1'b0;
    else if (rx_push)    rx_req <= 1'b1;
    else if (host_rx_rd) rx_req <= 1'b0;
  end

  // size registers and read data
  always_ff @(posedge clk) begin
    if (rst) begin
      blk_len_q  <= '0;
      blk_cnt_q  <= '0;
      host_rdata <= '0;
    end else begin
      if (host_we && host_addr == ADDR_BLK_LEN) blk_len_q <= host_wdata[LEN_W-1:0];
      if (host_we && host_addr == ADDR_BLK_CNT) blk_cnt_q <= host_wdata[CNT_W-1:0];
      if (host_re) begin
        case (host_addr)
          ADDR_BLK_LEN:  host_rdata <= DATA_W'(blk_len_q);
          ADDR_BLK_CNT,
          ADDR_BLK_LEFT: host_rdata <= DATA_W'(blk_cnt_q);
          ADDR_RX_PORT:  host_rdata <= rx_word;
          default:       host_rdata <= '0;
        endcase
      end
    end
  end

  cde_xfer_ctrl #(.CNT_W(REM_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .start(xfer_start), .start_wr(xfer_write),
    .start_len(REM_W'(blk_len_q) * REM_W'(blk_cnt_q)),
    .stop(xfer_stop), .byte_done(rx_push || tx_drain),
    .tx_eval(host_tx_wr || host_flush),
    .busy(busy), .wr_mode(wr_mode), .remaining(remaining),
    .data_done(data_done), .prog_done(prog_done), .tx_req(tx_req));

  // R1: the receive queue never exceeds its capacity
  p_rx_bound_r1: assert property (@(posedge clk) disable iff (rst)
    rx_level_q <= FULL_LVL);
  // R1: no receive handshake during a write transfer
  p_rx_dir_r1: assert property (@(posedge clk) disable iff (rst)
    card_rx_ready |-> busy && !wr_mode);
  // R2: bytes are offered to the card only in an active write transfer
  p_tx_dir_r2: assert property (@(posedge clk) disable iff (rst)
    card_tx_valid |-> busy && wr_mode);
  // R7: the transmit window never exceeds its capacity
  p_tx_bound_r7: assert property (@(posedge clk) disable iff (rst)
    tx_level_q <= FULL_LVL);
  // R3: a queued byte raises the receive request
  p_rxreq_set_r3: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> rx_req);
  // R11: a stalled offer is held unchanged
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (rst)
    card_tx_valid && !card_tx_ready && !xfer_start && !xfer_stop && !host_flush
    |=> (card_tx_valid && $stable(card_tx_data)) || xfer_start || xfer_stop);
endmodule

// File: tb/card_data_engine_tb_top.sv
module card_data_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_we, host_re;
  logic [2:0]  host_addr;
  logic [1:0]  host_size;
  logic [31:0] host_wdata, host_rdata;
  logic        xfer_start, xfer_write, xfer_stop;
  logic        card_rx_valid, card_rx_ready;
  logic [7:0]  card_rx_data;
  logic        card_tx_valid, card_tx_ready;
  logic [7:0]  card_tx_data;
  logic        busy, rx_req, tx_req, data_done, prog_done;

  always #5 clk = ~clk;

  card_data_engine dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .xfer_start(xfer_start), .xfer_write(xfer_write),
    .xfer_stop(xfer_stop), .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
    .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
    .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready), .busy(busy),
    .rx_req(rx_req), .tx_req(tx_req), .data_done(data_done), .prog_done(prog_done));

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // card model
  logic [7:0] src_mem [64];
  int         src_n = 0, src_idx = 0;
  bit         src_en = 0;
  logic [7:0] snk_mem [64];
  int         snk_n = 0;
  bit         snk_en = 0, snk_toggle = 0;
  int         cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    card_rx_valid <= src_en && (src_idx < src_n);
    card_rx_data  <= (src_idx < 64) ? src_mem[src_idx] : 8'h00;
    card_tx_ready <= snk_en && (!snk_toggle || cyc[1]);
  end

  always @(negedge clk) begin
    #4;
    if (card_rx_valid && card_rx_ready) src_idx++;
    if (card_tx_valid && card_tx_ready && snk_n < 64) begin
      snk_mem[snk_n] = card_tx_data;
      snk_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input int n, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_size = 2'(n - 1); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, input int n, output logic [31:0] d);
    @(negedge clk);
    host_re = 1'b1; host_addr = a; host_size = 2'(n - 1);
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic start_xfer(input bit wr);
    @(negedge clk);
    xfer_start = 1'b1; xfer_write = wr;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic wait_idle(input int maxc);
    for (int i = 0; i < maxc && busy; i++) @(negedge clk);
  endtask

  task automatic load_src(input int n, input logic [7:0] base);
    @(negedge clk);
    src_en = 0;
    for (int i = 0; i < n; i++) src_mem[i] = base + 8'(i);
    src_n = n; src_idx = 0;
  endtask

  task automatic test_reset();
    chk("R5 busy after reset", 32'(busy), 0);
    chk("R3 rx_req after reset", 32'(rx_req), 0);
    chk("R4 tx_req after reset", 32'(tx_req), 0);
    chk("R5 flags after reset", {30'd0, data_done, prog_done}, 0);
    chk("R10 card idle after reset", {30'd0, card_rx_ready, card_tx_valid}, 0);
  endtask

  task automatic test_regs();
    logic [31:0] d;
    host_wr(3'd0, 4, 32'h0000_FABC);
    host_rd(3'd0, 4, d); chk("R9 block length 12 bits", d, 32'h0000_0ABC);
    host_wr(3'd1, 4, 32'h0001_2345);
    host_rd(3'd1, 4, d); chk("R9 block count 16 bits", d, 32'h0000_2345);
    host_wr(3'd2, 4, 32'h0000_0007);
    host_rd(3'd2, 4, d); chk("R9 blocks left ignores write", d, 32'h0000_2345);
  endtask

  task automatic test_read_pack();
    logic [31:0] d;
    load_src(12, 8'h10);
    host_wr(3'd0, 4, 4); host_wr(3'd1, 4, 3);
    src_en = 1;
    start_xfer(0);
    wait_idle(100);
    chk("R5 read done", {30'd0, data_done, prog_done}, 32'h2);
    chk("R3 rx_req raised", 32'(rx_req), 1);
    chk("R1 all bytes taken", 32'(src_idx), 12);
    host_rd(3'd3, 4, d); chk("R6 four-byte read", d, 32'h1011_1213);
    chk("R3 rx_req cleared by read", 32'(rx_req), 0);
    host_rd(3'd3, 2, d); chk("R6 two-byte read", d, 32'h0000_1415);
    host_rd(3'd3, 1, d); chk("R6 one-byte read", d, 32'h0000_0016);
    host_rd(3'd3, 4, d); chk("R6 four-byte read 2", d, 32'h1718_191A);
    host_rd(3'd3, 4, d); chk("R6 short queue zero lanes", d, 32'h1B00_0000);
    host_rd(3'd3, 4, d); chk("R6 empty queue", d, 32'h0);
  endtask

  task automatic test_rx_full();
    logic [31:0] d;
    load_src(40, 8'h40);
    host_wr(3'd0, 4, 40); host_wr(3'd1, 4, 1);
    src_en = 1;
    start_xfer(0);
    repeat (50) @(negedge clk);
    chk("R1 queue stops at 32", 32'(src_idx), 32);
    chk("R1 ready low when full", 32'(card_rx_ready), 0);
    chk("R5 still busy", 32'(busy), 1);
    for (int j = 0; j < 10; j++) begin
      host_rd(3'd3, 4, d);
      chk("R1 order across wrap", d,
          {8'(8'h40 + 4*j), 8'(8'h41 + 4*j), 8'(8'h42 + 4*j), 8'(8'h43 + 4*j)});
    end
    wait_idle(100);
    chk("R5 long read done", 32'(data_done), 1);
  endtask

  task automatic test_write_stall();
    logic [7:0] exp [8] = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hB1, 8'hB2, 8'hC1, 8'hD1};
    snk_en = 0; snk_toggle = 0; snk_n = 0;
    host_wr(3'd0, 4, 8); host_wr(3'd1, 4, 1);
    start_xfer(1);
    chk("R4 tx_req at write start", 32'(tx_req), 1);
    chk("R5 start clears done", 32'(data_done), 0);
    host_wr(3'd4, 4, 32'hA1A2_A3A4);
    chk("R4 tx_req with bytes left", 32'(tx_req), 1);
    repeat (3) @(negedge clk);
    chk("R11 offer while stalled", {23'd0, card_tx_valid, card_tx_data}, 32'h1A1);
    repeat (2) @(negedge clk);
    chk("R11 offer held", {23'd0, card_tx_valid, card_tx_data}, 32'h1A1);
    snk_toggle = 1; snk_en = 1;
    host_wr(3'd4, 2, 32'h0000_B1B2);
    host_wr(3'd4, 1, 32'h0000_00C1);
    host_wr(3'd4, 4, 32'hD1D2_D3D4);
    wait_idle(200);
    chk("R2 byte count sent", 32'(snk_n), 8);
    for (int i = 0; i < 8; i++) chk("R7 lane order", 32'(snk_mem[i]), 32'(exp[i]));
    chk("R5 write done flags", {30'd0, data_done, prog_done}, 32'h3);
    chk("R4 tx_req cleared at end", 32'(tx_req), 0);
    snk_toggle = 0; snk_en = 0;
  endtask

  task automatic test_tx_full();
    snk_n = 0; snk_en = 0;
    host_wr(3'd0, 4, 40); host_wr(3'd1, 4, 1);
    start_xfer(1);
    for (int w = 0; w < 9; w++)
      host_wr(3'd4, 4, {8'(4*w), 8'(4*w + 1), 8'(4*w + 2), 8'(4*w + 3)});
    snk_en = 1;
    repeat (45) @(negedge clk);
    chk("R7 only 32 bytes queued", 32'(snk_n), 32);
    chk("R2 waits for more bytes", 32'(busy), 1);
    for (int i = 0; i < 32; i++) chk("R2 drain order", 32'(snk_mem[i]), i);
    host_wr(3'd4, 4, 32'hE0E1_E2E3);
    host_wr(3'd4, 4, 32'hE4E5_E6E7);
    wait_idle(100);
    chk("R2 total bytes", 32'(snk_n), 40);
    for (int i = 32; i < 40; i++) chk("R7 excess dropped", 32'(snk_mem[i]), 32'(8'hE0 + 8'(i - 32)));
    snk_en = 0;
  endtask

  task automatic test_flush();
    logic [7:0] exp [8] = '{8'h55, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAA, 8'hBB, 8'hCC};
    snk_n = 0; snk_en = 0;
    host_wr(3'd0, 4, 8); host_wr(3'd1, 4, 1);
    start_xfer(1);
    host_wr(3'd4, 4, 32'h1122_3344);
    host_wr(3'd5, 4, 32'h0000_0001);
    chk("R4 tx_req after flush", 32'(tx_req), 1);
    host_wr(3'd4, 4, 32'h5566_7788);
    host_wr(3'd5, 4, 32'h0000_0002);
    host_wr(3'd4, 4, 32'h99AA_BBCC);
    snk_en = 1;
    wait_idle(100);
    chk("R8 sent count", 32'(snk_n), 8);
    for (int i = 0; i < 8; i++) chk("R8 flushed bytes gone", 32'(snk_mem[i]), 32'(exp[i]));
    snk_en = 0;
  endtask

  task automatic test_stop();
    load_src(16, 8'h70);
    host_wr(3'd0, 4, 16); host_wr(3'd1, 4, 1);
    start_xfer(0);
    chk("R5 start clears done", 32'(data_done), 0);
    chk("R10 active before stop", 32'(busy), 1);
    @(negedge clk); xfer_stop = 1'b1;
    @(negedge clk); xfer_stop = 1'b0;
    src_en = 1;
    repeat (3) @(negedge clk);
    chk("R10 stopped", 32'(busy), 0);
    chk("R10 no done flags", {30'd0, data_done, prog_done}, 0);
    chk("R10 no card handshake", 32'(src_idx), 0);
    src_en = 0;
  endtask

  task automatic test_zero_len();
    host_wr(3'd0, 4, 0); host_wr(3'd1, 4, 5);
    start_xfer(1);
    repeat (2) @(negedge clk);
    chk("R5 zero length completes", {29'd0, busy, data_done, prog_done}, 32'h3);
    chk("R4 zero length no tx_req", 32'(tx_req), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; host_we = 0; host_re = 0; host_addr = 0; host_size = 0;
    host_wdata = 0; xfer_start = 0; xfer_write = 0; xfer_stop = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_regs();
    test_read_pack();
    test_rx_full();
    test_write_stall();
    test_tx_full();
    test_flush();
    test_stop();
    test_zero_len();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule